// File: doc/BRIEF.md
# Byte SECDED Codec

This block protects one byte with a 13-bit single-error-correcting, double-error-detecting code. The encoder half takes a data byte and produces a code word built from four position-weighted check bits, the eight data bits and a whole-word parity bit. The decoder half takes a received 13-bit word and recomputes the four checks and the whole-word parity. It returns the data byte, repaired when a single bit has flipped, with flags that say whether a repair was made or the word could not be recovered.

Both halves are combinational. The parameter `OUT_REG` chooses whether both halves drive their outputs straight through or through a register stage that costs one clock of latency. The code layout is derived from `DATA_W`: check bits sit at the power-of-two positions and the data bits fill the rest. At the default width of 8 this gives the 12+1 bit word described below. A typical use places the encoder on a write path and the decoder on the matching read path.

Top module: `secded_codec`

## Requirements
- R1: Word layout (DATA_W = 8): bit 12 of a code word is the whole-word parity bit. Code positions 1 to 12, counted from the left, sit at bits 11 down to 0, so position k is bit 12-k. Data bits 7 down to 0 fill positions 3, 5, 6, 7, 9, 10, 11, 12 in that order. For example, data 0xFF encodes to 0x0EEF and data 0x00 encodes to 0x0000.
- R2: Each check bit at position 2^i makes the XOR over all positions whose number has bit i set equal to zero. Check 1 covers positions 1,3,5,7,9,11. Check 2 covers 2,3,6,7,10,11. Check 4 covers 4,5,6,7,12. Check 8 covers 8,9,10,11,12.
- R3: Every encoded word has an even number of ones across all 13 bits.
- R4: A received word with no error returns its data byte with a zero syndrome and both flags low.
- R5: When exactly one of positions 1 to 12 is flipped, the syndrome equals that position number. The returned byte is the original data, the corrected flag is high and the uncorrectable flag is low.
- R6: When only the whole-word parity bit is flipped, the syndrome is zero and the corrected flag is high. The uncorrectable flag is low and the data is unchanged.
- R7: When two bits are flipped, the uncorrectable flag is high, the corrected flag is low and the syndrome is nonzero. The returned byte equals the data bits taken from the received word as they arrived. This applies to any two of the 13 bits.
- R8: A syndrome of 13, 14 or 15 points at no existing position, so it always raises the uncorrectable flag, whatever the whole-word parity says.
- R9: The corrected and uncorrectable flags are never high together.
- R10: With `OUT_REG` = 1, all outputs follow their inputs one clock later and read zero during reset. With `OUT_REG` = 0 they follow their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| enc_data_i | input | DATA_W (8) | Byte to encode |
| enc_word_o | output | DATA_W+CHK+1 (13) | Encoded word, parity bit in the MSB |
| dec_word_i | input | DATA_W+CHK+1 (13) | Received word to check and repair |
| dec_data_o | output | DATA_W (8) | Recovered byte |
| dec_corr_o | output | 1 | A single error was found and repaired |
| dec_uncorr_o | output | 1 | The word holds an error that cannot be repaired |
| dec_syn_o | output | CHK (4) | Syndrome: position number of the failing bit |

## Verification
The bound checker checks four properties on every clock. The two flags never coincide, and every encoded word has even weight. A zero syndrome never comes with the uncorrectable flag, and out-of-range syndromes always do. It also checks that a decoder input held steady yields steady outputs after the configured latency. Whether repaired data really equals the data originally sent can only be shown by the bench's scenarios. The same holds for which syndrome each error pattern produces and for the exact layout of check and data bits. These scenarios sweep every byte, every single-bit flip, every pair of flips and the triple flips that reach unused syndromes.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // smallest check-bit count p with 2^p >= data + p + 1
   function automatic int chk_count(input int dw);
      int p;
      p = 1;
      while ((1 << p) < dw + p + 1) p = p + 1;
      return p;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
   import secded_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CHK   = chk_count(DATA_W),
   localparam int NPOS  = DATA_W + CHK,
   localparam int CW    = NPOS + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CW-1:0]     word_o
);

   logic [NPOS:1] pos;

   always_comb begin
      int j;
      logic par;
      pos = '0;
      j   = DATA_W - 1;
      // data bits fill non-power-of-two positions, MSB first
      for (int k = 1; k <= NPOS; k++) begin
         if (!is_pow2(k)) begin
            pos[k] = data_i[j];
            j      = j - 1;
         end
      end
      // each check bit closes even parity over its group
      for (int i = 0; i < CHK; i++) begin
         par = 1'b0;
         for (int k = 1; k <= NPOS; k++) begin
            if (!is_pow2(k) && ((k >> i) & 1) == 1) par = par ^ pos[k];
         end
         pos[1 << i] = par;
      end
   end

   always_comb begin
      word_o[NPOS] = ^pos;
      for (int k = 1; k <= NPOS; k++) word_o[NPOS-k] = pos[k];
   end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
   import secded_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CHK   = chk_count(DATA_W),
   localparam int NPOS  = DATA_W + CHK,
   localparam int CW    = NPOS + 1
) (
   input  logic [CW-1:0]     word_i,
   output logic [DATA_W-1:0] data_o,
   output logic              corr_o,
   output logic              uncorr_o,
   output logic [CHK-1:0]    syn_o
);

   logic [NPOS:1] pos;
   logic [NPOS:1] fixed;
   logic [CHK-1:0] syn;
   logic mism;
   logic syn_zero;
   logic syn_valid;
   logic do_fix;

   always_comb begin
      for (int k = 1; k <= NPOS; k++) pos[k] = word_i[NPOS-k];
   end

   // syndrome bit i: parity of every position whose number has bit i set
   always_comb begin
      for (int i = 0; i < CHK; i++) begin
         syn[i] = 1'b0;
         for (int k = 1; k <= NPOS; k++) begin
            if (((k >> i) & 1) == 1) syn[i] = syn[i] ^ pos[k];
         end
      end
   end

   assign mism      = ^word_i;
   assign syn_zero  = (syn == '0);
   assign syn_valid = (int'(syn) <= NPOS);
   assign do_fix    = mism && !syn_zero && syn_valid;

   always_comb begin
      for (int k = 1; k <= NPOS; k++) fixed[k] = pos[k] ^ (do_fix && (int'(syn) == k));
   end

   always_comb begin
      int j;
      data_o = '0;
      j      = DATA_W - 1;
      for (int k = 1; k <= NPOS; k++) begin
         if (!is_pow2(k)) begin
            data_o[j] = fixed[k];
            j         = j - 1;
         end
      end
   end

   assign corr_o   = mism && (syn_zero || syn_valid);
   assign uncorr_o = (!mism && !syn_zero) || (mism && !syn_valid);
   assign syn_o    = syn;

endmodule

// File: rtl/secded_pipe.sv
module secded_pipe #(
   parameter int WIDTH = 8,
   parameter bit EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (EN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_wire
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/secded_codec.sv
module secded_codec
   import secded_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int CHK    = chk_count(DATA_W),
   localparam int CW     = DATA_W + CHK + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CW-1:0]     enc_word_o,
   input  logic [CW-1:0]     dec_word_i,
   output logic [DATA_W-1:0] dec_data_o,
   output logic              dec_corr_o,
   output logic              dec_uncorr_o,
   output logic [CHK-1:0]    dec_syn_o
);

   localparam int DEC_W = DATA_W + 2 + CHK;

   generate
      if (DATA_W < 4 || DATA_W > 57) begin : g_bad_width
         $error("secded_codec: DATA_W must lie in 4..57");
      end
   endgenerate

   logic [CW-1:0]     enc_word_c;
   logic [DATA_W-1:0] dec_data_c;
   logic              dec_corr_c;
   logic              dec_uncorr_c;
   logic [CHK-1:0]    dec_syn_c;

   secded_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (enc_data_i),
      .word_o (enc_word_c)
   );

   secded_dec #(.DATA_W(DATA_W)) u_dec (
      .word_i   (dec_word_i),
      .data_o   (dec_data_c),
      .corr_o   (dec_corr_c),
      .uncorr_o (dec_uncorr_c),
      .syn_o    (dec_syn_c)
   );

   secded_pipe #(.WIDTH(CW), .EN(OUT_REG)) u_enc_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (enc_word_c),
      .q     (enc_word_o)
   );

   secded_pipe #(.WIDTH(DEC_W), .EN(OUT_REG)) u_dec_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dec_data_c, dec_corr_c, dec_uncorr_c, dec_syn_c}),
      .q     ({dec_data_o, dec_corr_o, dec_uncorr_o, dec_syn_o})
   );

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
   import secded_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int CHK    = chk_count(DATA_W),
   localparam int NPOS   = DATA_W + CHK,
   localparam int CW     = NPOS + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CW-1:0]     enc_word_o,
   input logic [CW-1:0]     dec_word_i,
   input logic [DATA_W-1:0] dec_data_o,
   input logic              dec_corr_o,
   input logic              dec_uncorr_o,
   input logic [CHK-1:0]    dec_syn_o
);

   // R9
   excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_corr_o && dec_uncorr_o));

   // R3
   even_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^enc_word_o) == 1'b0);

   // R4
   zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_syn_o == '0) |-> !dec_uncorr_o);

   // R8
   high_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(dec_syn_o) > NPOS) |-> dec_uncorr_o);

   // R10
   generate
      if (OUT_REG) begin : g_lat1
         stable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(dec_word_i)) |=>
               ($stable(dec_data_o) && $stable(dec_syn_o) && $stable(dec_corr_o)));
      end else begin : g_lat0
         stable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(dec_word_i) |->
               ($stable(dec_data_o) && $stable(dec_syn_o) && $stable(dec_corr_o)));
      end
   endgenerate

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enc_word_o   (enc_word_o),
   .dec_word_i   (dec_word_i),
   .dec_data_o   (dec_data_o),
   .dec_corr_o   (dec_corr_o),
   .dec_uncorr_o (dec_uncorr_o),
   .dec_syn_o    (dec_syn_o)
);

// File: tb/secded_codec_bench.sv
module secded_codec_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  enc_data = 8'h00;
   logic [12:0] dec_word = 13'h0;
   logic [12:0] enc_word;
   logic [7:0]  dec_data;
   logic        dec_corr;
   logic        dec_uncorr;
   logic [3:0]  dec_syn;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   secded_codec u_secded_codec (
      .clk          (clk),
      .rst_n        (rst_n),
      .enc_data_i   (enc_data),
      .enc_word_o   (enc_word),
      .dec_word_i   (dec_word),
      .dec_data_o   (dec_data),
      .dec_corr_o   (dec_corr),
      .dec_uncorr_o (dec_uncorr),
      .dec_syn_o    (dec_syn)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference encoder written from the layout and coverage rules
   function automatic logic [12:0] ref_enc(input logic [7:0] d);
      logic [1:12] p;
      p = '0;
      p[3] = d[7]; p[5] = d[6]; p[6] = d[5]; p[7] = d[4];
      p[9] = d[3]; p[10] = d[2]; p[11] = d[1]; p[12] = d[0];
      p[1] = p[3] ^ p[5] ^ p[7] ^ p[9] ^ p[11];
      p[2] = p[3] ^ p[6] ^ p[7] ^ p[10] ^ p[11];
      p[4] = p[5] ^ p[6] ^ p[7] ^ p[12];
      p[8] = p[9] ^ p[10] ^ p[11] ^ p[12];
      return {^p, p};
   endfunction

   function automatic logic [12:0] flip(input logic [12:0] w, input int k);
      return w ^ (13'd1 << (12 - k));
   endfunction

   function automatic logic [7:0] raw_data(input logic [12:0] w);
      return {w[9], w[7], w[6], w[5], w[3], w[2], w[1], w[0]};
   endfunction

   task automatic drive(input logic [12:0] w, input logic [7:0] d);
      @(negedge clk);
      dec_word = w;
      enc_data = d;
      @(negedge clk);
   endtask

   task automatic t_reset();
      enc_data = 8'hFF;
      dec_word = 13'h1ABC;
      repeat (3) @(negedge clk);
      chk("R10 reset enc", 32'(enc_word), 32'h0);
      chk("R10 reset data", 32'(dec_data), 32'h0);
      chk("R10 reset flags", 32'({dec_corr, dec_uncorr, dec_syn}), 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_known();
      drive(13'h0, 8'hFF);
      chk("R1 ff encode", 32'(enc_word), 32'h0EEF);
      drive(13'h0, 8'h00);
      chk("R1 zero encode", 32'(enc_word), 32'h0000);
   endtask

   task automatic t_sweep();
      for (int d = 0; d < 256; d++) begin
         drive(ref_enc(8'(d)), 8'(d));
         chk("R2 encode", 32'(enc_word), 32'(ref_enc(8'(d))));
         chk("R3 even weight", 32'(^enc_word), 32'h0);
         chk("R4 clean data", 32'(dec_data), 32'(d));
         chk("R4 clean flags", 32'({dec_corr, dec_uncorr, dec_syn}), 32'h0);
      end
   endtask

   task automatic t_single();
      logic [7:0] pats [4] = '{8'h00, 8'hA5, 8'h3C, 8'hFF};
      for (int p = 0; p < 4; p++) begin
         for (int k = 1; k <= 12; k++) begin
            drive(flip(ref_enc(pats[p]), k), 8'h00);
            chk("R5 data", 32'(dec_data), 32'(pats[p]));
            chk("R5 syndrome", 32'(dec_syn), 32'(k));
            chk("R5 flags", 32'({dec_corr, dec_uncorr}), 32'b10);
         end
      end
   endtask

   task automatic t_p0();
      logic [7:0] pats [3] = '{8'h00, 8'h96, 8'hFF};
      for (int p = 0; p < 3; p++) begin
         drive(ref_enc(pats[p]) ^ 13'h1000, 8'h00);
         chk("R6 data", 32'(dec_data), 32'(pats[p]));
         chk("R6 syndrome", 32'(dec_syn), 32'h0);
         chk("R6 flags", 32'({dec_corr, dec_uncorr}), 32'b10);
      end
   endtask

   task automatic t_double();
      logic [12:0] w;
      for (int a = 1; a <= 12; a++) begin
         for (int b = a + 1; b <= 12; b++) begin
            w = flip(flip(ref_enc(8'h5A), a), b);
            drive(w, 8'h00);
            chk("R7 syndrome", 32'(dec_syn), 32'(a ^ b));
            chk("R7 flags", 32'({dec_corr, dec_uncorr}), 32'b01);
            chk("R7 raw data", 32'(dec_data), 32'(raw_data(w)));
            chk("R9 flags exclusive", 32'(dec_corr & dec_uncorr), 32'h0);
         end
         w = flip(ref_enc(8'hC3), a) ^ 13'h1000;
         drive(w, 8'h00);
         chk("R7 p0 pair syndrome", 32'(dec_syn), 32'(a));
         chk("R7 p0 pair flags", 32'({dec_corr, dec_uncorr}), 32'b01);
      end
   endtask

   task automatic t_high_syn();
      logic [12:0] w;
      w = flip(flip(flip(ref_enc(8'h00), 1), 4), 8);
      drive(w, 8'h00);
      chk("R8 syn13", 32'(dec_syn), 32'd13);
      chk("R8 syn13 flags", 32'({dec_corr, dec_uncorr}), 32'b01);
      chk("R8 syn13 data", 32'(dec_data), 32'(raw_data(w)));
      w = flip(flip(flip(ref_enc(8'h7E), 2), 4), 8);
      drive(w, 8'h00);
      chk("R8 syn14", 32'(dec_syn), 32'd14);
      chk("R8 syn14 flags", 32'({dec_corr, dec_uncorr}), 32'b01);
      w = flip(flip(flip(ref_enc(8'h81), 3), 4), 8);
      drive(w, 8'h00);
      chk("R8 syn15", 32'(dec_syn), 32'd15);
      chk("R8 syn15 flags", 32'({dec_corr, dec_uncorr}), 32'b01);
   endtask

   task automatic t_latency();
      drive(ref_enc(8'h11), 8'h11);
      @(negedge clk);
      dec_word = ref_enc(8'h22);
      enc_data = 8'h22;
      #1;
      chk("R10 held data", 32'(dec_data), 32'h11);
      chk("R10 held enc", 32'(enc_word), 32'(ref_enc(8'h11)));
      @(posedge clk);
      #1;
      chk("R10 new data", 32'(dec_data), 32'h22);
      chk("R10 new enc", 32'(enc_word), 32'(ref_enc(8'h22)));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_known();
      t_sweep();
      t_single();
      t_p0();
      t_double();
      t_high_syn();
      t_latency();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule